// File: doc/BRIEF.md
# Programmable Asynchronous Serial Transmitter

This block turns a parallel character into one asynchronous serial frame on a single output line. Each frame is a low start bit, five to eight data bits sent least significant bit first, an optional odd or even parity bit, and a high stop period of one, one and a half or two bit times. The block runs from a clock at sixteen times the bit rate, so every ordinary bit lasts sixteen clock cycles.

The frame format comes from a five-bit control word, which is captured only when its load strobe is high. A character written with the data load strobe waits in a holding buffer. It moves to the shift engine as soon as the engine is free, so the next character can be written while the current one is still being sent. Two flags report the state: one says the holding buffer is free, the other says that both the buffer and the engine are empty and the last stop period has ended.

Top module: `ser_frame_tx`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block resets. After that edge `txd` is 1, `buf_empty` is 1, `shreg_empty` is 1, and the stored control word is 5'b00000 (5 data bits, parity on and odd, one stop bit).
- R2: `cfg_word` is stored only at an edge where `cfg_load` is 1, and is ignored at all other times. A frame keeps the format that was stored when its character entered the shift engine, even if the control word is reloaded while the frame is being sent.
- R3: Field `cfg_word[1:0]` sets the data length: 00 gives 5 bits, 01 gives 6, 10 gives 7 and 11 gives 8. A frame starts with one start bit of value 0. The data bits follow, least significant first, and each bit lasts 16 clock cycles.
- R4: When `cfg_word[2]` is 1, the frame has no parity bit. When it is 0, a parity bit follows the last data bit. With `cfg_word[3]` = 1 the parity is even: the parity bit equals the XOR of the data bits. With `cfg_word[3]` = 0 the parity is odd: the parity bit is the inverse of that XOR.
- R5: The stop period is at 1. With `cfg_word[4]` = 0 it lasts 16 cycles. With `cfg_word[4]` = 1 it lasts 24 cycles for 5-bit characters and 32 cycles for 6, 7 or 8-bit characters.
- R6: If `din_load` is 1 at edge L, `buf_empty` is 0 after edge L. If the engine is idle, the start bit begins after edge L+1, and `buf_empty` is 1 again from that edge.
- R7: A character loaded while another frame is being sent starts its start bit in the cycle right after the last stop cycle of that frame. There is no idle cycle between the two frames.
- R8: `shreg_empty` is 1 only when the holding buffer is empty and the final stop period has ended. It stays 0 for every cycle of a frame, including frames sent back to back.
- R9: `txd` is 1 whenever no frame is being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at 16 times the bit rate |
| rst_n | input | 1 | Synchronous active-low master reset |
| cfg_load | input | 1 | Strobe that stores `cfg_word` |
| cfg_word | input | 5 | Format word: [1:0] length, [2] parity off, [3] even parity, [4] long stop |
| din | input | 8 | Character to send; only the low length bits are used |
| din_load | input | 1 | Strobe that writes `din` into the holding buffer |
| buf_empty | output | 1 | Holding buffer can accept a character |
| shreg_empty | output | 1 | Buffer and shift engine are both empty |
| txd | output | 1 | Serial output line |

## Verification
Directed frames cover every data length with each parity mode and both stop selections, using the data patterns 00, FF, 55 and AA. These patterns separate a wrong bit order, a wrong parity sense and a stop period that is short by half a bit. Back-to-back pairs, each with a control-word reload in the middle of the first frame, show whether the second frame starts without a gap and whether the first frame keeps its own format. A change on the control-word input with no strobe checks that the input is ignored. After these, seeded random formats and data are checked cycle by cycle against a waveform that the bench computes.

// File: rtl/ser_tx_pkg.sv
// Shared types and format helpers for the serial frame transmitter.
// Assumes: control word layout {long_stop, even, no_par, len[1:0]}.
package ser_tx_pkg;

    typedef struct packed {
        logic       long_stop;
        logic       even;
        logic       no_par;
        logic [1:0] len;
    } tx_fmt_t;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_START,
        PH_DATA,
        PH_PAR,
        PH_STOP
    } phase_t;

    // Number of data bits selected by the length field.
    function automatic int fmt_bits(tx_fmt_t f);
        return 5 + int'(f.len);
    endfunction

    // Stop period in clock cycles for oversample factor ovs.
    function automatic int stop_cycles(tx_fmt_t f, int ovs);
        if (!f.long_stop)
            return ovs;
        else if (f.len == 2'b00)
            return ovs + ovs / 2;
        else
            return 2 * ovs;
    endfunction

endpackage

// File: rtl/ser_tx_cfg.sv
// Control word register: stores the frame format on its load strobe.
// Assumes: strobe is synchronous to clk; reset format is all zero.
module ser_tx_cfg
    import ser_tx_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    load,
    input  tx_fmt_t word_i,
    output tx_fmt_t fmt_o
);

    tx_fmt_t fmt_q;

    // Capture the format word only when strobed.
    always_ff @(posedge clk) begin
        if (!rst_n)
            fmt_q <= '0;
        else if (load)
            fmt_q <= word_i;
    end

    assign fmt_o = fmt_q;

    a_r2_hold_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && $past(rst_n)) |=> $stable(fmt_q));

endmodule

// File: rtl/ser_tx_hold.sv
// Holding buffer: keeps one character until the shift engine takes it.
// Assumes: a load in the same cycle as a take refills the buffer.
module ser_tx_hold #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [DW-1:0] din,
    input  logic          take,
    output logic [DW-1:0] data_o,
    output logic          full_o
);

    logic [DW-1:0] data_q;
    logic          full_q;

    // Track occupancy; a load has priority over a take.
    always_ff @(posedge clk) begin
        if (!rst_n)
            full_q <= 1'b0;
        else if (load)
            full_q <= 1'b1;
        else if (take)
            full_q <= 1'b0;
    end

    // Store the character on a load.
    always_ff @(posedge clk) begin
        if (!rst_n)
            data_q <= '0;
        else if (load)
            data_q <= din;
    end

    assign data_o = data_q;
    assign full_o = full_q;

    a_r6_load_fills: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> full_q);

    a_r6_take_frees: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !load) |=> !full_q);

endmodule

// File: rtl/ser_tx_shift.sv
// Frame engine: sends start, data (LSB first), optional parity and stop.
// Assumes: take only when ready_o; format and parity fixed at take.
module ser_tx_shift
    import ser_tx_pkg::*;
#(
    parameter int OVS = 16,
    parameter int DW  = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          take,
    input  logic [DW-1:0] data_i,
    input  tx_fmt_t       fmt_i,
    output logic          ready_o,
    output logic          idle_o,
    output logic          txd_o
);

    localparam int CW = $clog2(2 * OVS);
    localparam int BW = $clog2(DW + 1);
    localparam logic [CW-1:0] BIT_LAST = CW'(OVS - 1);

    phase_t        phase;
    logic [CW-1:0] cnt;
    logic [DW-1:0] sh;
    logic [BW-1:0] left;
    tx_fmt_t       fmt_q;
    logic          par_q;
    logic          txd_q;
    logic          last_cyc;
    logic          par_new;
    logic [CW-1:0] stop_last;

    assign last_cyc = (cnt == '0);

    // Parity of the incoming character over its selected length.
    always_comb begin
        logic [DW-1:0] mask;
        mask = '0;
        for (int b = 0; b < DW; b++)
            mask[b] = (b < fmt_bits(fmt_i));
        par_new = fmt_i.even ? ^(data_i & mask) : ~^(data_i & mask);
    end

    assign stop_last = CW'(stop_cycles(fmt_q, OVS) - 1);

    // Phase sequencer, bit-time counter and output register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            cnt   <= '0;
            sh    <= '0;
            left  <= '0;
            fmt_q <= '0;
            par_q <= 1'b0;
            txd_q <= 1'b1;
        end else if (take) begin
            phase <= PH_START;
            cnt   <= BIT_LAST;
            sh    <= data_i;
            left  <= BW'(fmt_bits(fmt_i));
            fmt_q <= fmt_i;
            par_q <= par_new;
            txd_q <= 1'b0;
        end else if (phase != PH_IDLE) begin
            if (!last_cyc) begin
                cnt <= cnt - 1'b1;
            end else begin
                case (phase)
                    PH_START, PH_DATA: begin
                        if (left != '0) begin
                            phase <= PH_DATA;
                            txd_q <= sh[0];
                            sh    <= sh >> 1;
                            left  <= left - 1'b1;
                            cnt   <= BIT_LAST;
                        end else if (!fmt_q.no_par) begin
                            phase <= PH_PAR;
                            txd_q <= par_q;
                            cnt   <= BIT_LAST;
                        end else begin
                            phase <= PH_STOP;
                            txd_q <= 1'b1;
                            cnt   <= stop_last;
                        end
                    end
                    PH_PAR: begin
                        phase <= PH_STOP;
                        txd_q <= 1'b1;
                        cnt   <= stop_last;
                    end
                    default: begin
                        phase <= PH_IDLE;
                        txd_q <= 1'b1;
                    end
                endcase
            end
        end
    end

    assign ready_o = (phase == PH_IDLE) || (phase == PH_STOP && last_cyc);
    assign idle_o  = (phase == PH_IDLE);
    assign txd_o   = txd_q;

    a_r9_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_IDLE) |-> txd_q);

    a_r3_start_low: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_START) |-> !txd_q);

    a_r5_stop_high: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_STOP) |-> txd_q);

    a_r4_parity_only_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_PAR) |-> !fmt_q.no_par);

    a_r7_no_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_STOP && last_cyc && take) |=> (phase == PH_START));

    a_r6_take_when_ready: assert property (@(posedge clk) disable iff (!rst_n)
        take |-> ready_o);

endmodule

// File: rtl/ser_frame_tx.sv
// Programmable asynchronous serial transmitter top level.
// Assumes: clk runs at OVS times the bit rate; reset is synchronous, active low.
module ser_frame_tx
    import ser_tx_pkg::*;
#(
    parameter int OVS = 16,
    parameter int DW  = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_load,
    input  logic [4:0]    cfg_word,
    input  logic [DW-1:0] din,
    input  logic          din_load,
    output logic          buf_empty,
    output logic          shreg_empty,
    output logic          txd
);

    tx_fmt_t       fmt;
    logic [DW-1:0] hold_data;
    logic          hold_full;
    logic          eng_ready;
    logic          eng_idle;
    logic          take;

    ser_tx_cfg u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (cfg_load),
        .word_i (tx_fmt_t'(cfg_word)),
        .fmt_o  (fmt)
    );

    ser_tx_hold #(.DW(DW)) u_hold (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (din_load),
        .din    (din),
        .take   (take),
        .data_o (hold_data),
        .full_o (hold_full)
    );

    ser_tx_shift #(.OVS(OVS), .DW(DW)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .take    (take),
        .data_i  (hold_data),
        .fmt_i   (fmt),
        .ready_o (eng_ready),
        .idle_o  (eng_idle),
        .txd_o   (txd)
    );

    // Hand the buffered character over as soon as the engine frees up.
    assign take        = eng_ready && hold_full;
    assign buf_empty   = !hold_full;
    assign shreg_empty = eng_idle && !hold_full;

    a_r8_empty_means_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        shreg_empty |-> (buf_empty && txd));

endmodule

// File: tb/tb_ser_frame_tx.sv
// Self-checking bench: directed corner frames plus seeded random frames.
module tb_ser_frame_tx;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_load = 1'b0;
    logic [4:0] cfg_word = '0;
    logic [7:0] din = '0;
    logic       din_load = 1'b0;
    logic       buf_empty, shreg_empty, txd;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [4:0] mcfg = '0;

    always #2.5 clk = ~clk;

    ser_frame_tx dut (
        .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_word(cfg_word),
        .din(din), .din_load(din_load), .buf_empty(buf_empty),
        .shreg_empty(shreg_empty), .txd(txd)
    );

    function automatic int nbits(logic [4:0] c);
        return 5 + int'(c[1:0]);
    endfunction

    function automatic int stop_len(logic [4:0] c);
        if (!c[4]) return 16;
        return (c[1:0] == 2'b00) ? 24 : 32;
    endfunction

    function automatic int frame_len(logic [4:0] c);
        return 16 * (1 + nbits(c) + (c[2] ? 0 : 1)) + stop_len(c);
    endfunction

    function automatic logic exp_txd(logic [4:0] c, logic [7:0] d, int i);
        int k = i / 16;
        logic p = 1'b0;
        for (int b = 0; b < nbits(c); b++) p ^= d[b];
        if (!c[3]) p = ~p;
        if (k == 0) return 1'b0;
        if (k <= nbits(c)) return d[k-1];
        if (!c[2] && k == nbits(c) + 1) return p;
        return 1'b1;
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic set_cfg(logic [4:0] c);
        @(negedge clk);
        cfg_word = c;
        cfg_load = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0;
        mcfg = c;
    endtask

    // Send d1 with the model format; with two set, queue d2 under format c2
    // (reloaded mid-frame) and check both frames back to back.
    task automatic run_seq(logic [7:0] d1, bit two, logic [4:0] c2, logic [7:0] d2, string tag);
        logic [4:0] ca = mcfg;
        int la = frame_len(ca);
        int tot = la + (two ? frame_len(c2) : 0);
        int bad_i = -1;
        int bad_v = 0;
        int bad_e = 0;
        bit busy_ok = 1;
        @(negedge clk);
        din = d1;
        din_load = 1'b1;
        @(posedge clk);
        @(negedge clk);
        din_load = 1'b0;
        check(!buf_empty && !shreg_empty, {"R6 flags after load ", tag}, buf_empty, 0);
        @(posedge clk);
        for (int i = 0; i < tot; i++) begin
            logic e;
            @(negedge clk);
            e = (i < la) ? exp_txd(ca, d1, i) : exp_txd(c2, d2, i - la);
            if (txd !== e && bad_i < 0) begin
                bad_i = i; bad_v = txd; bad_e = e;
            end
            if (shreg_empty !== 1'b0) busy_ok = 0;
            if (i == 0) check(buf_empty === 1'b1, {"R6 buffer freed at start ", tag}, buf_empty, 1);
            if (two && i == 3) begin din = d2; din_load = 1'b1; end
            if (two && i == 4) begin
                din_load = 1'b0;
                check(buf_empty === 1'b0, {"R7 second char held ", tag}, buf_empty, 0);
                cfg_word = c2; cfg_load = 1'b1;
            end
            if (two && i == 5) cfg_load = 1'b0;
            if (!two && i == 4) cfg_word = ~ca;
            if (two && i == la) check(buf_empty === 1'b1, {"R7 second frame started ", tag}, buf_empty, 1);
        end
        if (two) mcfg = c2;
        if (bad_i >= 0)
            $display("  mismatch at cycle %0d of %s", bad_i, tag);
        check(bad_i < 0, {"R3 R4 R5 R7 waveform ", tag}, bad_v, bad_e);
        check(busy_ok, {"R8 shreg_empty low during frame ", tag}, busy_ok, 1);
        @(negedge clk);
        check(shreg_empty === 1'b1 && txd === 1'b1, {"R8 R9 idle after frame ", tag}, {shreg_empty, txd}, 3);
        repeat (2) @(negedge clk);
        check(txd === 1'b1, {"R9 line idle ", tag}, txd, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] pats [4] = '{8'h00, 8'hFF, 8'h55, 8'hAA};
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(txd === 1'b1 && buf_empty === 1'b1 && shreg_empty === 1'b1,
              "R1 reset state", {txd, buf_empty, shreg_empty}, 7);
        // R1: reset format is 5 bits, odd parity, one stop.
        run_seq(8'h13, 0, '0, '0, "reset format R1");
        // R2: cfg_word was changed without a strobe; the old format applies.
        run_seq(8'hC6, 0, '0, '0, "unstrobed word ignored R2");
        // Directed sweep of length, parity mode and stop select.
        for (int c = 0; c < 32; c++) begin
            set_cfg(5'(c));
            run_seq(pats[c % 4], 0, '0, '0, $sformatf("dir cfg %0d", c));
        end
        // R5 corners: 1.5 stop on 5 bits and 2 stop on 8 bits.
        set_cfg(5'b10100);
        run_seq(8'h1F, 0, '0, '0, "R5 5-bit long stop");
        set_cfg(5'b10111);
        run_seq(8'h80, 0, '0, '0, "R5 8-bit long stop");
        // R7 and R2: back-to-back frames with a format reload mid-frame.
        set_cfg(5'b00011);
        run_seq(8'hA5, 1, 5'b10100, 8'h0B, "R7 pair 8->5");
        run_seq(8'h15, 1, 5'b01110, 8'h7E, "R7 pair 5->7");
        // Seeded random sequences.
        for (int n = 0; n < 40; n++) begin
            logic [4:0] c = 5'($urandom);
            set_cfg(c);
            if (($urandom % 3) == 0)
                run_seq(8'($urandom), 1, 5'($urandom), 8'($urandom), $sformatf("rnd pair %0d", n));
            else
                run_seq(8'($urandom), 0, '0, '0, $sformatf("rnd %0d", n));
        end
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule